// File: doc/BRIEF.md
# Asynchronous DRAM Access Sequencer

This block sits between a simple single-request host port and an asynchronous DRAM device. For every host read or write it produces the full strobe sequence on the device pins. The row half of the host address goes on a shared address bus while the active-low row strobe is still high. The row strobe then falls, the bus switches to the column half, and the column strobe falls. The level of the write-enable pin at that falling edge tells the device whether the cycle is a read or a write. The block also controls the direction of the data pins. It drives write data itself, and it turns its driver off and opens the device output while read data is being returned.

A separate refresh scheduler may raise a refresh request. The sequencer grants it only while idle, which is always after a full precharge. It then runs a column-before-row refresh cycle, so the device's internal row counter chooses the row. When a refresh request and a host request are both present in an idle cycle, the refresh goes first. Each phase length (row address setup, row-to-column delay, column pulse, precharge) is a parameter counted in clock cycles.

Top module: `adram_sequencer`

## Requirements
- R1: In reset and while idle, all four strobes are high, the data driver is off, the address bus is 0, and `host_ready` is high unless a refresh is pending.
- R2: After a host request is accepted, the row address (`host_addr[ADDR_W-1:COL_W]`) is on the bus with every strobe high for T_ASR cycles. The row strobe then falls with the row address still on the bus, and the bus keeps the row address for that first row-strobe-low cycle.
- R3: The column address (`host_addr[COL_W-1:0]`, zero-extended) is on the bus for the remaining T_RCD-1 row-strobe-low cycles before the column strobe falls. The column strobe then stays low for T_CAS cycles, and the row strobe stays low throughout.
- R4: During a write, write enable is low and the write data is driven from the first row-strobe-low cycle until the column strobe rises. Output enable stays high for the whole cycle.
- R5: During a read, write enable stays high and the data driver is off. Output enable is low only while the column strobe is low. `host_rdata` becomes the value on `dram_dq_in` in the last column-low cycle.
- R6: `host_done` is high for exactly one cycle, the first cycle of precharge after a host access. `host_rdata` keeps its value through writes and refreshes.
- R7: After each cycle, both strobes stay high for T_RP cycles of precharge and then at least one idle cycle. No strobe falls before that time has passed.
- R8: A request is accepted on a clock edge where `host_req` and `host_ready` are both high. `host_ready` is low during every access, refresh and precharge, and a request held through that time waits.
- R9: A refresh is granted in an idle cycle with `ref_req` high, and `ref_ack` is high in that cycle. The column strobe is then low for T_CAS cycles with the row strobe high, and after that both are low for T_CAS cycles. Write and output enable stay high, the bus is 0 and no `host_done` is given.
- R10: When `ref_req` and `host_req` are both high in an idle cycle, `host_ready` is low and the refresh runs first. The host request is accepted after the refresh precharge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | Host access request, held until accepted |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W | Host word address, row in the upper bits |
| host_wdata | input | DATA_W | Write data |
| host_ready | output | 1 | Sequencer can accept a request this cycle |
| host_done | output | 1 | One-cycle completion pulse |
| host_rdata | output | DATA_W | Data from the latest read |
| ref_req | input | 1 | Refresh request from the scheduler |
| ref_ack | output | 1 | Refresh granted this cycle |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_addr | output | MUX_W | Multiplexed row/column address |
| dram_dq_out | output | DATA_W | Data driven toward the device |
| dram_dq_oe | output | 1 | Enables the block's data driver |
| dram_dq_in | input | DATA_W | Data returned by the device |

## Verification
A refresh request and a host request can arrive in the same idle cycle, and the arbiter has to settle that collision in a single cycle. The bench raises both inputs at the same instant. It then checks that `host_ready` drops while `ref_ack` rises, that the next cycle starts a column-first refresh rather than a row-address setup, and that the held host request goes out only after the refresh precharge. A behavioural model of the device in the bench latches the address on the strobe edges and returns data only inside the read window. As a result, any timing slip between the address bus and a strobe edge shows up as wrong read data.

// File: rtl/adram_pkg.sv
package adram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RSET,
    ST_ROWACT,
    ST_COLACT,
    ST_REFC,
    ST_REFR,
    ST_PRE
  } seq_state_e;

  // cycles spent in a phase
  function automatic int unsigned phase_cycles(seq_state_e s, int unsigned t_asr,
                                               int unsigned t_rcd, int unsigned t_cas,
                                               int unsigned t_rp);
    case (s)
      ST_RSET:   return t_asr;
      ST_ROWACT: return t_rcd;
      ST_COLACT: return t_cas;
      ST_REFC:   return t_cas;
      ST_REFR:   return t_cas;
      ST_PRE:    return t_rp;
      default:   return 1;
    endcase
  endfunction

  function automatic int unsigned max_of4(int unsigned a, int unsigned b,
                                          int unsigned c, int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

  function automatic logic row_low(seq_state_e s);
    return (s == ST_ROWACT) || (s == ST_COLACT) || (s == ST_REFR);
  endfunction

  function automatic logic col_low(seq_state_e s);
    return (s == ST_COLACT) || (s == ST_REFC) || (s == ST_REFR);
  endfunction

  function automatic logic in_access(seq_state_e s);
    return (s == ST_ROWACT) || (s == ST_COLACT);
  endfunction

endpackage

// File: rtl/adram_phase_timer.sv
module adram_phase_timer #(
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             last
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (load)            cnt_q <= load_val;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign last = (cnt_q == '0);

endmodule

// File: rtl/adram_seq_fsm.sv
module adram_seq_fsm
  import adram_pkg::*;
#(
  parameter int unsigned T_ASR = 1,
  parameter int unsigned T_RCD = 2,
  parameter int unsigned T_CAS = 2,
  parameter int unsigned T_RP  = 3,
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_req,
  input  logic             ref_req,
  input  logic             phase_last,
  output seq_state_e       state_q,
  output seq_state_e       state_nxt,
  output logic             advance,
  output logic [CNT_W-1:0] load_val,
  output logic             grant_host,
  output logic             grant_ref
);

  localparam int unsigned DWELL_W = CNT_W + 1;

  always_comb begin
    state_nxt = state_q;
    case (state_q)
      ST_IDLE: begin
        if (ref_req)       state_nxt = ST_REFC;
        else if (host_req) state_nxt = ST_RSET;
      end
      ST_RSET:   if (phase_last) state_nxt = ST_ROWACT;
      ST_ROWACT: if (phase_last) state_nxt = ST_COLACT;
      ST_COLACT: if (phase_last) state_nxt = ST_PRE;
      ST_REFC:   if (phase_last) state_nxt = ST_REFR;
      ST_REFR:   if (phase_last) state_nxt = ST_PRE;
      ST_PRE:    if (phase_last) state_nxt = ST_IDLE;
      default:   state_nxt = ST_IDLE;
    endcase
  end

  assign advance    = (state_nxt != state_q);
  assign grant_ref  = (state_q == ST_IDLE) && ref_req;
  assign grant_host = (state_q == ST_IDLE) && !ref_req && host_req;
  assign load_val   = CNT_W'(phase_cycles(state_nxt, T_ASR, T_RCD, T_CAS, T_RP) - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_nxt;
  end

  // independent dwell counter, used only to cross-check the phase timer
  logic [DWELL_W-1:0] dwell_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       dwell_q <= DWELL_W'(1);
    else if (advance)                 dwell_q <= DWELL_W'(1);
    else if (dwell_q != '1)           dwell_q <= dwell_q + 1'b1;
  end

  AST_COL_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && state_q == ST_COLACT) |-> (dwell_q == DWELL_W'(T_CAS))); // R3
  AST_PRECHARGE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && state_q == ST_PRE) |-> (dwell_q == DWELL_W'(T_RP))); // R7
  AST_ROW_SETUP_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && state_q == ST_RSET) |-> (dwell_q == DWELL_W'(T_ASR))); // R2

endmodule

// File: rtl/adram_pin_driver.sv
module adram_pin_driver
  import adram_pkg::*;
#(
  parameter int unsigned MUX_W  = 9,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned T_RP   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seq_state_e        state_q,
  input  seq_state_e        state_nxt,
  input  logic              op_we,
  input  logic [MUX_W-1:0]  row_addr,
  input  logic [MUX_W-1:0]  col_addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] dq_in,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic              oe_n,
  output logic [MUX_W-1:0]  addr,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  output logic              done,
  output logic [DATA_W-1:0] rdata
);

  localparam int unsigned HI_W = $clog2(T_RP + 1) + 1;

  logic              acc_nxt, row_hold, col_end, dq_oe_d;
  logic [MUX_W-1:0]  addr_d;

  always_comb begin
    acc_nxt  = in_access(state_nxt);
    row_hold = (state_nxt == ST_RSET) || (state_nxt == ST_ROWACT && state_q == ST_RSET);
    col_end  = (state_q == ST_COLACT) && (state_nxt == ST_PRE);
    dq_oe_d  = acc_nxt && op_we;
    if (row_hold)     addr_d = row_addr;
    else if (acc_nxt) addr_d = col_addr;
    else              addr_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ras_n  <= 1'b1;
      cas_n  <= 1'b1;
      we_n   <= 1'b1;
      oe_n   <= 1'b1;
      addr   <= '0;
      dq_out <= '0;
      dq_oe  <= 1'b0;
      done   <= 1'b0;
      rdata  <= '0;
    end else begin
      ras_n  <= !row_low(state_nxt);
      cas_n  <= !col_low(state_nxt);
      we_n   <= !(acc_nxt && op_we);
      oe_n   <= !((state_nxt == ST_COLACT) && !op_we);
      addr   <= addr_d;
      dq_out <= dq_oe_d ? wdata : '0;
      dq_oe  <= dq_oe_d;
      done   <= col_end;
      if (col_end && !op_we) rdata <= dq_in;
    end
  end

  // consecutive cycles with both strobes high, saturating at T_RP
  logic [HI_W-1:0] hi_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 hi_cnt <= HI_W'(T_RP);
    else if (ras_n && cas_n)    hi_cnt <= (hi_cnt >= HI_W'(T_RP)) ? HI_W'(T_RP) : hi_cnt + 1'b1;
    else                        hi_cnt <= '0;
  end

  AST_ROW_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> $stable(addr)); // R2
  AST_COL_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cas_n) && !ras_n) |-> $stable(addr)); // R3
  AST_WRITE_DATA_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cas_n) && !we_n) |-> (dq_oe && $past(dq_oe) && $stable(dq_out))); // R4
  AST_NO_BUS_FIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    !(dq_oe && !oe_n)); // R5
  AST_ROW_HELD_THROUGH_COL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> (cas_n && $past(!cas_n))); // R3
  AST_PRECHARGE_MET: assert property (@(posedge clk) disable iff (!rst_n)
    (($fell(ras_n) && $past(cas_n)) || ($fell(cas_n) && $past(ras_n)))
      |-> (hi_cnt >= HI_W'(T_RP))); // R7
  AST_REFRESH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!cas_n && ras_n) |-> (we_n && oe_n && !dq_oe)); // R9
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6

endmodule

// File: rtl/adram_sequencer.sv
module adram_sequencer
  import adram_pkg::*;
#(
  parameter int unsigned ROW_W  = 9,
  parameter int unsigned COL_W  = 8,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned T_ASR  = 1,
  parameter int unsigned T_RCD  = 2,
  parameter int unsigned T_CAS  = 2,
  parameter int unsigned T_RP   = 3,
  localparam int unsigned ADDR_W = ROW_W + COL_W,
  localparam int unsigned MUX_W  = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_req,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic              host_ready,
  output logic              host_done,
  output logic [DATA_W-1:0] host_rdata,
  input  logic              ref_req,
  output logic              ref_ack,
  output logic              dram_ras_n,
  output logic              dram_cas_n,
  output logic              dram_we_n,
  output logic              dram_oe_n,
  output logic [MUX_W-1:0]  dram_addr,
  output logic [DATA_W-1:0] dram_dq_out,
  output logic              dram_dq_oe,
  input  logic [DATA_W-1:0] dram_dq_in
);

  localparam int unsigned MAX_PH = max_of4(T_ASR, T_RCD, T_CAS, T_RP);
  localparam int unsigned CNT_W  = $clog2(MAX_PH + 1);

  function automatic logic [MUX_W-1:0] row_of(logic [ADDR_W-1:0] a);
    return MUX_W'(a[ADDR_W-1:COL_W]);
  endfunction

  function automatic logic [MUX_W-1:0] col_of(logic [ADDR_W-1:0] a);
    return MUX_W'(a[COL_W-1:0]);
  endfunction

  initial begin
    AST_PARAM_RANGE: assert (T_ASR >= 1 && T_RCD >= 2 && T_CAS >= 1 && T_RP >= 1); // R3
  end

  seq_state_e        state_q, state_nxt;
  logic              advance, phase_last, grant_host, grant_ref;
  logic [CNT_W-1:0]  load_val;

  adram_seq_fsm #(
    .T_ASR(T_ASR), .T_RCD(T_RCD), .T_CAS(T_CAS), .T_RP(T_RP), .CNT_W(CNT_W)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_req   (host_req),
    .ref_req    (ref_req),
    .phase_last (phase_last),
    .state_q    (state_q),
    .state_nxt  (state_nxt),
    .advance    (advance),
    .load_val   (load_val),
    .grant_host (grant_host),
    .grant_ref  (grant_ref)
  );

  adram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (advance),
    .load_val (load_val),
    .last     (phase_last)
  );

  // request capture; the grant cycle forwards the live host fields
  logic              op_we_q;
  logic [MUX_W-1:0]  row_q, col_q;
  logic [DATA_W-1:0] wdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_we_q <= 1'b0;
      row_q   <= '0;
      col_q   <= '0;
      wdata_q <= '0;
    end else if (grant_host) begin
      op_we_q <= host_we;
      row_q   <= row_of(host_addr);
      col_q   <= col_of(host_addr);
      wdata_q <= host_wdata;
    end
  end

  logic              cur_we;
  logic [MUX_W-1:0]  cur_row, cur_col;
  logic [DATA_W-1:0] cur_wdata;

  assign cur_we    = grant_host ? host_we             : op_we_q;
  assign cur_row   = grant_host ? row_of(host_addr)   : row_q;
  assign cur_col   = grant_host ? col_of(host_addr)   : col_q;
  assign cur_wdata = grant_host ? host_wdata          : wdata_q;

  adram_pin_driver #(.MUX_W(MUX_W), .DATA_W(DATA_W), .T_RP(T_RP)) u_pins (
    .clk       (clk),
    .rst_n     (rst_n),
    .state_q   (state_q),
    .state_nxt (state_nxt),
    .op_we     (cur_we),
    .row_addr  (cur_row),
    .col_addr  (cur_col),
    .wdata     (cur_wdata),
    .dq_in     (dram_dq_in),
    .ras_n     (dram_ras_n),
    .cas_n     (dram_cas_n),
    .we_n      (dram_we_n),
    .oe_n      (dram_oe_n),
    .addr      (dram_addr),
    .dq_out    (dram_dq_out),
    .dq_oe     (dram_dq_oe),
    .done      (host_done),
    .rdata     (host_rdata)
  );

  assign host_ready = (state_q == ST_IDLE) && !ref_req;
  assign ref_ack    = grant_ref;

  AST_READY_ONLY_PRECHARGED: assert property (@(posedge clk) disable iff (!rst_n)
    host_ready |-> (dram_ras_n && dram_cas_n && !dram_dq_oe)); // R8
  AST_REFRESH_BEFORE_HOST: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req && host_req && host_ready) |-> 1'b0); // R10
  AST_NO_DONE_AFTER_REFRESH: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(dram_ras_n) && dram_we_n && dram_oe_n && $past(dram_oe_n) && $past(dram_we_n, 2))
      |-> (host_done == (state_q == ST_PRE && $past(state_q) == ST_COLACT))); // R9

endmodule

// File: tb/adram_sequencer_tb.sv
module adram_sequencer_tb;

  localparam int ROW_W  = 9;
  localparam int COL_W  = 8;
  localparam int DATA_W = 16;
  localparam int T_ASR  = 2;
  localparam int T_RCD  = 3;
  localparam int T_CAS  = 2;
  localparam int T_RP   = 3;
  localparam int ADDR_W = ROW_W + COL_W;
  localparam int MUX_W  = (ROW_W > COL_W) ? ROW_W : COL_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              host_req = 1'b0, host_we = 1'b0, ref_req = 1'b0;
  logic [ADDR_W-1:0] host_addr = '0;
  logic [DATA_W-1:0] host_wdata = '0;
  logic              host_ready, host_done, ref_ack;
  logic [DATA_W-1:0] host_rdata;
  logic              dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n, dram_dq_oe;
  logic [MUX_W-1:0]  dram_addr;
  logic [DATA_W-1:0] dram_dq_out, dram_dq_in;

  always #10 clk = ~clk;

  adram_sequencer #(
    .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W),
    .T_ASR(T_ASR), .T_RCD(T_RCD), .T_CAS(T_CAS), .T_RP(T_RP)
  ) u_dut (
    .clk(clk), .rst_n(rst_n),
    .host_req(host_req), .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_ready(host_ready), .host_done(host_done), .host_rdata(host_rdata),
    .ref_req(ref_req), .ref_ack(ref_ack),
    .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
    .dram_oe_n(dram_oe_n), .dram_addr(dram_addr), .dram_dq_out(dram_dq_out),
    .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in)
  );

  // ---------------- behavioural device model ----------------
  int                row_l = 0, col_l = 0;
  logic [DATA_W-1:0] dram_mem [int];

  always @(negedge dram_ras_n) row_l = int'(dram_addr);
  always @(negedge dram_cas_n)
    if (dram_ras_n === 1'b0) begin
      col_l = int'(dram_addr);
      if (dram_we_n === 1'b0) dram_mem[row_l * (2 ** COL_W) + col_l] = dram_dq_out;
    end

  always @* begin
    if (!dram_ras_n && !dram_cas_n && dram_we_n && !dram_oe_n)
      dram_dq_in = dram_mem.exists(row_l * (2 ** COL_W) + col_l) ?
                   dram_mem[row_l * (2 ** COL_W) + col_l] : '0;
    else
      dram_dq_in = 16'hDEAD;
  end

  // ---------------- bookkeeping ----------------
  int n_checks = 0, n_err = 0;
  bit finished = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", n_checks, n_err);
      $finish;
    end
  endtask

  // ---------------- cycle reference model ----------------
  typedef struct packed {
    logic ras, cas, we, oe, dqoe;
    logic [MUX_W-1:0]  a;
    logic [DATA_W-1:0] dq;
    logic done;
    logic rd;
    logic [DATA_W-1:0] rv;
    logic [3:0] rid;
  } snap_t;

  snap_t exp_q[$];
  logic [DATA_W-1:0] mdl_mem [int];
  logic [DATA_W-1:0] last_rd = '0;

  function automatic snap_t mk(logic ras, logic cas, logic we, logic oe, logic dqoe,
                               logic [MUX_W-1:0] a, logic [DATA_W-1:0] dq, logic done,
                               logic rd, logic [DATA_W-1:0] rv, int rid);
    snap_t s;
    s.ras = ras; s.cas = cas; s.we = we; s.oe = oe; s.dqoe = dqoe;
    s.a = a; s.dq = dq; s.done = done; s.rd = rd; s.rv = rv; s.rid = 4'(rid);
    return s;
  endfunction

  task automatic push_acc(input logic w, input logic [ADDR_W-1:0] ad, input logic [DATA_W-1:0] wd);
    logic [MUX_W-1:0]  r, c;
    logic [DATA_W-1:0] dq, rv;
    r  = MUX_W'(ad / (2 ** COL_W));
    c  = MUX_W'(ad % (2 ** COL_W));
    dq = w ? wd : '0;
    for (int i = 0; i < T_ASR; i++) exp_q.push_back(mk(1,1,1,1,0, r, '0, 0,0,'0, 2));
    exp_q.push_back(mk(0,1,!w,1,w, r, dq, 0,0,'0, 2));
    for (int i = 1; i < T_RCD; i++) exp_q.push_back(mk(0,1,!w,1,w, c, dq, 0,0,'0, w ? 4 : 3));
    for (int i = 0; i < T_CAS; i++) exp_q.push_back(mk(0,0,!w,w,w, c, dq, 0,0,'0, w ? 4 : 5));
    if (w) begin
      mdl_mem[int'(ad)] = wd;
      rv = last_rd;
    end else begin
      rv = mdl_mem.exists(int'(ad)) ? mdl_mem[int'(ad)] : '0;
      last_rd = rv;
    end
    exp_q.push_back(mk(1,1,1,1,0, '0, '0, 1,1, rv, w ? 6 : 5));
    for (int i = 1; i < T_RP; i++) exp_q.push_back(mk(1,1,1,1,0, '0, '0, 0,0,'0, 7));
  endtask

  task automatic push_ref();
    for (int i = 0; i < T_CAS; i++) exp_q.push_back(mk(1,0,1,1,0, '0, '0, 0,0,'0, 9));
    for (int i = 0; i < T_CAS; i++) exp_q.push_back(mk(0,0,1,1,0, '0, '0, 0,0,'0, 9));
    for (int i = 0; i < T_RP;  i++) exp_q.push_back(mk(1,1,1,1,0, '0, '0, 0,0,'0, 7));
  endtask

  always @(posedge clk) begin
    if (!rst_n)                exp_q.delete();
    else if (exp_q.size() != 0) void'(exp_q.pop_front());
    else if (ref_req)          push_ref();      // R10 refresh wins
    else if (host_req)         push_acc(host_we, host_addr, host_wdata);
  end

  always @(negedge clk) begin
    snap_t e;
    logic  idle_e;
    if (rst_n && !finished) begin
      idle_e = (exp_q.size() == 0);
      e = idle_e ? mk(1,1,1,1,0, '0, '0, 0,0,'0, 1) : exp_q[0];
      chk($sformatf("R%0d pins/handshake (R8 ready)", e.rid),
          64'({dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n, dram_dq_oe, dram_addr,
               dram_dq_out, host_done, host_ready, ref_ack}),
          64'({e.ras, e.cas, e.we, e.oe, e.dqoe, e.a, e.dq, e.done,
               idle_e && !ref_req, idle_e && ref_req}));
      if (e.rd) chk($sformatf("R%0d host_rdata", e.rid), 64'(host_rdata), 64'(e.rv));
    end
  end

  // ---------------- stimulus ----------------
  task automatic host_op(input logic w, input logic [ADDR_W-1:0] ad,
                         input logic [DATA_W-1:0] wd, input bit keep);
    @(negedge clk); #1;
    host_req = 1; host_we = w; host_addr = ad; host_wdata = wd;
    #1;
    while (!host_ready) begin @(negedge clk); #2; end
    @(negedge clk); #1;
    if (!keep) host_req = 0;
  endtask

  task automatic ref_op();
    @(negedge clk); #1;
    ref_req = 1;
    #1;
    while (!ref_ack) begin @(negedge clk); #2; end
    @(negedge clk); #1;
    ref_req = 0;
  endtask

  task automatic settle();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  localparam logic [ADDR_W-1:0] A_MAX = '1;
  localparam logic [ADDR_W-1:0] A_MID = {9'h0A5, 8'h3C};
  localparam logic [ADDR_W-1:0] A_HI  = {9'h1FF, 8'h00};
  localparam logic [ADDR_W-1:0] A_LO  = {9'h000, 8'hFF};

  initial begin
    #200000;  // 10,000 cycles
    n_err++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 reset strobes/ready", 64'({dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n, dram_dq_oe, host_ready}),
        64'(6'b111101));
    chk("R1 reset address", 64'(dram_addr), 64'(0));
    @(negedge clk); #1 rst_n = 1;

    // R4 R11: writes at the address extremes and a middle address
    host_op(1, '0, 16'h1234, 0);
    host_op(1, A_MAX, 16'hBEEF, 0);
    host_op(1, A_MID, 16'h5A5A, 0);
    host_op(1, A_LO, 16'h0F0F, 0);
    // R5: reads return the stored words through the read window
    host_op(0, A_MID, '0, 0);
    host_op(0, A_MAX, '0, 0);
    host_op(0, '0, '0, 0);
    host_op(0, A_LO, '0, 0);
    // R6: a write after a read leaves host_rdata unchanged
    host_op(1, A_MID, 16'h7777, 0);
    // R8 R7: request held continuously, back to back
    host_op(1, A_HI, 16'hC0DE, 1);
    host_op(0, A_HI, '0, 1);
    host_op(0, A_MID, '0, 0);
    // R5: unwritten location reads as zero from the device model
    host_op(0, {9'h033, 8'h44}, '0, 0);
    settle();

    // R9: refresh alone
    ref_op();
    settle();
    chk("R6 rdata kept over refresh", 64'(host_rdata), 64'(0));

    // R10: refresh and host request raised in the same idle cycle
    @(negedge clk); #1;
    ref_req = 1; host_req = 1; host_we = 0; host_addr = A_HI; host_wdata = '0;
    #1;
    chk("R10 ready low on collision", 64'(host_ready), 64'(0));
    chk("R10 refresh granted", 64'(ref_ack), 64'(1));
    @(negedge clk);
    chk("R10 column strobe first", 64'({dram_cas_n, dram_ras_n}), 64'(2'b01));
    #1 ref_req = 0;
    #1;
    while (!host_ready) begin @(negedge clk); #2; end
    @(negedge clk); #1 host_req = 0;
    settle();
    chk("R10 host read after refresh", 64'(host_rdata), 64'(16'hC0DE));

    // R11: device saw row/column split of the top address
    chk("R11 device row/col mapping", 64'(dram_mem.exists(int'(A_MAX)) ? dram_mem[int'(A_MAX)] : 16'h0),
        64'(16'hBEEF));
    chk("R11 device mapping low col", 64'(dram_mem.exists(int'(A_LO)) ? dram_mem[int'(A_LO)] : 16'h0),
        64'(16'h0F0F));

    finish_run();
  end

endmodule